// File: doc/BRIEF.md
# Shared Timer/Watchdog Prescaler

This block holds an 8-bit up-counting timer and a watchdog counter that share one programmable power-of-two prescaler. A control byte decides which of the two paths owns the prescaler and at what ratio; the path that does not own it advances once per base event, with no division. The timer advances either on an instruction-cycle tick or on a selected edge of an external pin, which passes through a two-flop synchroniser first. When the timer wraps from 255 to 0 it raises a sticky overflow flag. When the watchdog counter wraps it emits a single-cycle timeout pulse.

The prescaler count is hidden. Nothing on the bus can read or load it. Software clears it indirectly, and the action that does so depends on which path owns it. If the timer owns it, a write to the timer count clears it. If the watchdog owns it, the watchdog-clear strobe clears it. After any write to the timer count, the timer ignores the next two instruction ticks before it resumes counting.

Top module: `tmr_wdt_share`

## Requirements
- R1: After reset, the control byte reads 8'hFF, the timer count reads 0, the overflow flag is 0 and no timeout pulse is present.
- R2: The control byte is decoded as follows. Bit 3 set gives the prescaler to the watchdog and bit 3 clear gives it to the timer. Bits 2:0 hold the ratio code r. Bit 5 set makes the timer count external-pin edges, and bit 5 clear makes it count ticks. When bit 5 is set, bit 4 clear selects rising edges and bit 4 set selects falling edges. A control write takes effect from the next cycle.
- R3: With bit 3 clear, the timer advances once every 2^(r+1) source events, and the watchdog advances on every tick.
- R4: With bit 3 set, the watchdog advances once every 2^r ticks, and the timer advances on every source event.
- R5: With bit 3 clear, a timer-count write loads the count and clears the prescaler. It leaves the control byte unchanged.
- R6: The watchdog-clear strobe zeroes the watchdog counter. It also clears the prescaler, but only when bit 3 is set.
- R7: The external pin is sampled through two flops and then an edge detector, so an edge changes the count no earlier than the third clock after the pin moves.
- R8: After a timer-count write, the next two ticks do not advance the timer.
- R9: An advance from 255 to 0 sets the overflow flag. The flag stays set until the flag-clear strobe. If a set and a clear fall in the same cycle, the set wins. A count write never sets the flag.
- R10: The timeout output is high for exactly one cycle, in the cycle after the watchdog counter advances from its maximum value to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Instruction-cycle tick |
| ext_pin | input | 1 | Asynchronous external count pin |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_q | output | 8 | Control byte readback |
| cnt_wr | input | 1 | Timer count write strobe |
| cnt_wdata | input | 8 | Timer count write data |
| cnt_q | output | 8 | Timer count readback |
| wdt_clr | input | 1 | Watchdog clear strobe |
| flag_clr | input | 1 | Overflow flag clear strobe |
| ovf_flag | output | 1 | Sticky timer overflow flag |
| wdt_timeout | output | 1 | Single-cycle watchdog timeout pulse |

## Verification
Assertions check several rules on every cycle. The prescaler is empty in the cycle after any clear, a divided output never fires on two cycles in a row, and the timer holds still while the post-write hold is active. The overflow flag stays set until it is cleared, and the watchdog is zero after a clear with its timeout never lasting two cycles. Only the bench scenarios can show the correct division ratio for each ownership and code, the swap of clearing sources when ownership moves, and the edge polarity and latency of the external pin. They also show the exact cycle in which overflow and timeout appear, across random mixes of writes, clears and control changes.

// File: rtl/tws_pkg.sv
// Package: shared types for the timer/watchdog prescaler block.
// Assumes an 8-bit control byte with the field layout below.
package tws_pkg;
    localparam int RATIO_W = 3;

    typedef struct packed {
        logic                 spare7;
        logic                 spare6;
        logic                 ext_src;   // 1: count external pin edges
        logic                 fall_edge; // 1: falling edge, 0: rising edge
        logic                 to_wdt;    // 1: prescaler owned by watchdog
        logic [RATIO_W-1:0]   ratio;     // ratio code
    } ctl_t;

    localparam logic [7:0] CTL_RESET = 8'hFF;
endpackage

// File: rtl/tws_edge_src.sv
// Module: tws_edge_src
// Produces the timer source event. It is either the tick or a chosen edge of
// the external pin after a synchroniser chain. Assumes SYNC_STAGES >= 2 and
// that the pin is slow compared with clk.
module tws_edge_src #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    input  logic ext_src,
    input  logic fall_edge,
    output logic src_ev
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rise_ev;
    logic                   fall_ev;

    // Shift the pin through the synchroniser and keep the previous synced level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Detect edges and pick the timer source.
    always_comb begin
        rise_ev = sync_q[SYNC_STAGES-1] & ~prev_q;
        fall_ev = ~sync_q[SYNC_STAGES-1] & prev_q;
        if (ext_src) src_ev = fall_edge ? fall_ev : rise_ev;
        else         src_ev = tick;
    end
endmodule

// File: rtl/tws_prescaler.sv
// Module: tws_prescaler
// Power-of-two event divider shared by the timer and watchdog paths. Its
// count cannot be seen from outside. The owner-dependent ratio offset is
// applied here. Assumes clr wins over in_ev in the same cycle.
module tws_prescaler
    import tws_pkg::*;
#(
    parameter int R_W = RATIO_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_ev,
    input  logic           clr,
    input  logic           to_wdt,
    input  logic [R_W-1:0] ratio,
    output logic           out_ev
);
    localparam int PS_W = 1 << R_W;
    localparam int N_W  = R_W + 1;

    logic [PS_W-1:0] ps_q;
    logic [PS_W-1:0] mask;
    logic [N_W-1:0]  nbits;
    logic            full;

    // Number of low count bits that must be all ones before an output event.
    always_comb nbits = to_wdt ? {1'b0, ratio} : ({1'b0, ratio} + N_W'(1));

    for (genvar i = 0; i < PS_W; i++) begin : g_mask
        assign mask[i] = (N_W'(i) < nbits);
    end

    // Emit an output event when the selected low bits are all ones.
    always_comb begin
        full   = ((ps_q & mask) == mask);
        out_ev = in_ev & ~clr & full;
    end

    // Count input events; a clear empties the count.
    always_ff @(posedge clk) begin
        if (!rst_n)     ps_q <= '0;
        else if (clr)   ps_q <= '0;
        else if (in_ev) ps_q <= ps_q + PS_W'(1);
    end

    a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ps_q == '0));
    a_r3_no_double_out: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ev && nbits != '0) |=> (!out_ev || nbits == '0 || nbits != $past(nbits)));
endmodule

// File: rtl/tws_timer.sv
// Module: tws_timer
// Loadable up-counter with a post-write hold of HOLD_TICKS ticks and a
// sticky overflow flag. The source event is gated by the hold here, and the
// gated event is offered to the prescaler. inc is the final advance request.
module tws_timer #(
    parameter int CNT_W      = 8,
    parameter int HOLD_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             src_ev,
    input  logic             inc,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             flag_clr,
    output logic             gated_ev,
    output logic [CNT_W-1:0] count_q,
    output logic             flag_q
);
    localparam int HOLD_W = $clog2(HOLD_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [HOLD_W-1:0] hold_q;
    logic              wrap;

    // Block source events while the post-write hold is active.
    always_comb begin
        gated_ev = src_ev & (hold_q == '0);
        wrap     = inc & ~cnt_wr & (count_q == CNT_MAX);
    end

    // Load on write, otherwise advance; the hold runs down on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            hold_q  <= '0;
        end else if (cnt_wr) begin
            count_q <= cnt_wdata;
            hold_q  <= HOLD_W'(HOLD_TICKS);
        end else begin
            if (inc)                       count_q <= count_q + CNT_W'(1);
            if (tick && hold_q != '0)      hold_q  <= hold_q - HOLD_W'(1);
        end
    end

    // Sticky overflow flag; a set beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (wrap)     flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    a_r8_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q != '0 && !cnt_wr) |=> $stable(count_q));
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);
    a_r9_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !cnt_wr && count_q == CNT_MAX) |=> (flag_q && count_q == '0));
endmodule

// File: rtl/tws_watchdog.sv
// Module: tws_watchdog
// Watchdog up-counter that advances on ev. It makes a registered one-cycle
// pulse when it wraps from all ones to zero. Assumes clr wins over ev.
module tws_watchdog #(
    parameter int WDT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ev,
    input  logic clr,
    output logic timeout_q
);
    localparam logic [WDT_W-1:0] WDT_MAX = '1;

    logic [WDT_W-1:0] cnt_q;

    // Count events, wrap, and flag the wrap for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q     <= '0;
            timeout_q <= 1'b0;
        end else begin
            timeout_q <= ev && (cnt_q == WDT_MAX);
            if (ev) cnt_q <= cnt_q + WDT_W'(1);
        end
    end

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_q |=> !timeout_q);
    a_r6_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && !timeout_q));
endmodule

// File: rtl/tmr_wdt_share.sv
// Module: tmr_wdt_share (top)
// Holds the control byte and sends the one prescaler to either the timer or
// the watchdog. The prescaler's input and its clear source follow the owner,
// and the path without the prescaler runs at its base event rate.
module tmr_wdt_share
    import tws_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int WDT_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_TICKS  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ext_pin,
    input  logic             ctl_wr,
    input  logic [7:0]       ctl_wdata,
    output logic [7:0]       ctl_q,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt_q,
    input  logic             wdt_clr,
    input  logic             flag_clr,
    output logic             ovf_flag,
    output logic             wdt_timeout
);
    ctl_t ctl;
    logic src_ev, gated_ev, ps_in, ps_clr, ps_out, tmr_inc, wdt_ev;

    // Control byte register, reset to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= CTL_RESET;
        else if (ctl_wr) ctl_q <= ctl_wdata;
    end

    // Route the prescaler by ownership.
    always_comb begin
        ctl     = ctl_t'(ctl_q);
        ps_in   = ctl.to_wdt ? tick    : gated_ev;
        ps_clr  = ctl.to_wdt ? wdt_clr : cnt_wr;
        tmr_inc = ctl.to_wdt ? gated_ev : ps_out;
        wdt_ev  = ctl.to_wdt ? ps_out   : tick;
    end

    tws_edge_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pin(ext_pin),
        .ext_src(ctl.ext_src), .fall_edge(ctl.fall_edge), .src_ev(src_ev)
    );

    tws_prescaler #(.R_W(RATIO_W)) u_ps (
        .clk(clk), .rst_n(rst_n), .in_ev(ps_in), .clr(ps_clr),
        .to_wdt(ctl.to_wdt), .ratio(ctl.ratio), .out_ev(ps_out)
    );

    tws_timer #(.CNT_W(CNT_W), .HOLD_TICKS(HOLD_TICKS)) u_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .src_ev(src_ev), .inc(tmr_inc),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .flag_clr(flag_clr),
        .gated_ev(gated_ev), .count_q(cnt_q), .flag_q(ovf_flag)
    );

    tws_watchdog #(.WDT_W(WDT_W)) u_wdt (
        .clk(clk), .rst_n(rst_n), .ev(wdt_ev), .clr(wdt_clr), .timeout_q(wdt_timeout)
    );

    a_r5_write_keeps_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && !ctl_wr) |=> $stable(ctl_q));
endmodule

// File: tb/tmr_wdt_share_bench.sv
`timescale 1ns/1ps
module tmr_wdt_share_bench;
    localparam int WDT_W = 6;
    localparam logic [WDT_W-1:0] WMAX = '1;

    logic clk = 0, rst_n = 0, tick = 0, ext_pin = 0, ctl_wr = 0, cnt_wr = 0;
    logic wdt_clr = 0, flag_clr = 0;
    logic [7:0] ctl_wdata = 0, cnt_wdata = 0, ctl_q, cnt_q;
    logic ovf_flag, wdt_timeout;
    int checks = 0, errors = 0, cycles = 0;
    bit chk_en = 0;
    string phase = "R1";

    always #2 clk = ~clk;

    tmr_wdt_share #(.WDT_W(WDT_W)) u_tmr_wdt_share (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ext_pin(ext_pin),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt_q(cnt_q),
        .wdt_clr(wdt_clr), .flag_clr(flag_clr),
        .ovf_flag(ovf_flag), .wdt_timeout(wdt_timeout)
    );

    // Reference model built from the requirements.
    logic [7:0] m_ctl, m_ps, m_cnt;
    logic [1:0] m_inh;
    logic m_s1, m_s2, m_prev, m_flag, m_to;
    logic [WDT_W-1:0] m_wdt;

    function automatic logic [7:0] low_mask(input int n);
        return (n >= 8) ? 8'hFF : 8'((1 << n) - 1);
    endfunction

    always @(posedge clk) begin
        logic src, gsrc, asg, ps_in, ps_clr, psout, tinc, wev;
        int n;
        if (!rst_n) begin
            m_ctl <= 8'hFF; m_ps <= 0; m_cnt <= 0; m_inh <= 0;
            m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_flag <= 0; m_to <= 0; m_wdt <= 0;
        end else begin
            src  = m_ctl[5] ? (m_ctl[4] ? (!m_s2 && m_prev) : (m_s2 && !m_prev)) : tick;
            gsrc = src && (m_inh == 0);
            asg  = m_ctl[3];
            n    = asg ? int'(m_ctl[2:0]) : int'(m_ctl[2:0]) + 1;
            ps_in  = asg ? tick : gsrc;
            ps_clr = asg ? wdt_clr : cnt_wr;
            psout  = ps_in && !ps_clr && ((m_ps & low_mask(n)) == low_mask(n));
            tinc   = asg ? gsrc : psout;
            wev    = asg ? psout : tick;
            m_s1 <= ext_pin; m_s2 <= m_s1; m_prev <= m_s2;
            if (ps_clr) m_ps <= 0; else if (ps_in) m_ps <= m_ps + 1;
            if (cnt_wr) begin m_cnt <= cnt_wdata; m_inh <= 2; end
            else begin
                if (tinc) m_cnt <= m_cnt + 1;
                if (tick && m_inh != 0) m_inh <= m_inh - 1;
            end
            if (!cnt_wr && tinc && m_cnt == 8'hFF) m_flag <= 1;
            else if (flag_clr) m_flag <= 0;
            if (wdt_clr) begin m_wdt <= 0; m_to <= 0; end
            else begin m_to <= wev && (m_wdt == WMAX); if (wev) m_wdt <= m_wdt + 1; end
            if (ctl_wr) m_ctl <= ctl_wdata;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Compare every output against the model at each falling edge.
    always @(negedge clk) begin
        if (rst_n && chk_en) begin
            check(phase, "cnt_q", cnt_q, m_cnt);
            check(phase, "ovf_flag", ovf_flag, m_flag);
            check("R10", "wdt_timeout", wdt_timeout, m_to);
            check("R2", "ctl_q", ctl_q, m_ctl);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual %0d expected <150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic cyc(); @(posedge clk); @(negedge clk); endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_wr = 1; ctl_wdata = v; cyc(); ctl_wr = 0;
    endtask

    task automatic rand_run(input string req, input logic [7:0] ctl, input int n);
        phase = req;
        wr_ctl(ctl);
        for (int i = 0; i < n; i++) begin
            tick     = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 5) == 0) ext_pin = ~ext_pin;
            cnt_wr   = ($urandom_range(0, 60) == 0);
            cnt_wdata = 8'($urandom_range(240, 255));
            wdt_clr  = ($urandom_range(0, 90) == 0);
            flag_clr = ($urandom_range(0, 12) == 0);
            cyc();
        end
        cnt_wr = 0; wdt_clr = 0; flag_clr = 0;
    endtask

    initial begin
        int pulses;
        void'($urandom(32'h5EED_2024));
        repeat (4) cyc();
        rst_n = 1;
        // R1: reset state
        check("R1", "ctl_q", ctl_q, 8'hFF);
        check("R1", "cnt_q", cnt_q, 0);
        check("R1", "ovf_flag", ovf_flag, 0);
        check("R1", "wdt_timeout", wdt_timeout, 0);
        chk_en = 1;

        // R8/R9: watchdog owns prescaler, timer unscaled; load FE with tick held
        phase = "R9";
        wr_ctl(8'h08);
        tick = 1; cnt_wr = 1; cnt_wdata = 8'hFE; cyc(); cnt_wr = 0;
        cyc(); cyc(); cyc();
        check("R8", "cnt_q after two held ticks", cnt_q, 8'hFF);
        check("R9", "flag before wrap", ovf_flag, 0);
        cyc();
        check("R9", "cnt_q after wrap", cnt_q, 0);
        check("R9", "flag after wrap", ovf_flag, 1);
        cyc(); cyc();
        check("R9", "flag held", ovf_flag, 1);
        flag_clr = 1; cyc(); flag_clr = 0;
        check("R9", "flag cleared", ovf_flag, 0);

        // R5: count write leaves control byte unchanged
        wr_ctl(8'h02);
        cnt_wr = 1; cnt_wdata = 8'h10; cyc(); cnt_wr = 0;
        check("R5", "ctl_q after count write", ctl_q, 8'h02);
        check("R5", "cnt_q loaded", cnt_q, 8'h10);

        // R10: timer owns prescaler, watchdog unscaled: one pulse per 64 ticks
        wr_ctl(8'h00);
        tick = 1; wdt_clr = 1; cyc(); wdt_clr = 0;
        pulses = 0;
        for (int i = 0; i < 200; i++) begin cyc(); if (wdt_timeout) pulses++; end
        check("R10", "timeout pulses in 200 ticks", pulses, 3);

        // Random mixes per ownership, ratio and source
        rand_run("R3", 8'h00, 1500);
        rand_run("R3", 8'h02, 1500);
        rand_run("R4", 8'h08, 1500);
        rand_run("R4", 8'h0B, 1500);
        rand_run("R6", 8'h09, 1500);
        rand_run("R7", 8'h20, 1500);
        rand_run("R7", 8'h30, 1500);
        rand_run("R7", 8'h38, 1500);
        rand_run("R2", 8'h19, 1500);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule